// File: doc/BRIEF.md
# Byte-Wide Memory-Mapped Console Port

This block sits on a processor bus with 12-bit addresses and 16-bit data and gives software one byte-wide input channel and one byte-wide output channel. It claims four consecutive word addresses at the top of the address space and ignores every other address. Two of those addresses are data registers and two are status registers.

Each status register reports its flag in the sign bit of the word. A polling loop therefore only needs a negative test on the value it loads. The input side holds the most recent byte from the device and raises an "available" flag. A processor read of the input data register lowers that flag at the same clock edge, so no separate acknowledge write is needed.

The output side accepts a byte from a processor write only while it is ready. It presents that byte to the device with a valid/acknowledge handshake and stays busy until the device acknowledges. Bus reads are combinational from registered state: `bus_rdata` is valid in the same cycle that `bus_rd` is high.

Top module: `byte_port_io`

## Requirements
- R1: After reset the input-available flag is 0, the output side is ready, `dev_out_valid` is 0, and a read of 0xFFD returns 0x0000 while a read of 0xFFF returns 0x8000.
- R2: A read of 0xFFC returns the held input byte in bits 7:0, with bits 15:8 equal to zero.
- R3: A read of 0xFFD returns the input-available flag in bit 15, with bits 14:0 equal to zero.
- R4: When `dev_in_valid` is high at a clock edge, `dev_in_byte` is stored and the available flag is set. If the flag was already set, the new byte replaces the old one.
- R5: A read of 0xFFC clears the available flag at that clock edge. If a new byte arrives in the same cycle, the flag stays set and the new byte is held.
- R6: A write to 0xFFE while the output side is ready drives `dev_out_byte` with `bus_wdata[7:0]` and raises `dev_out_valid` from the next cycle. Bits 15:8 of the write data have no effect.
- R7: A read of 0xFFF returns the ready flag in bit 15, with bits 14:0 equal to zero. Ready is the inverse of `dev_out_valid`.
- R8: A write to 0xFFE while the ready flag is clear is dropped: `dev_out_byte` and `dev_out_valid` keep their values.
- R9: While `dev_out_valid` is high, `dev_out_ack` high at a clock edge lowers `dev_out_valid` and sets ready from the next cycle. An acknowledge while idle has no effect.
- R10: Reads of any address other than 0xFFC..0xFFF return 0x0000, and writes to them change no state. When `bus_rd` is low, `bus_rdata` is 0x0000.
- R11: A read of 0xFFE returns 0x0000. Writes to 0xFFC, 0xFFD and 0xFFF change neither channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| dev_in_valid | input | 1 | Input device presents a byte this cycle |
| dev_in_byte | input | 8 | Byte from the input device |
| dev_out_valid | output | 1 | A byte is waiting for the output device |
| dev_out_byte | output | 8 | Byte for the output device |
| dev_out_ack | input | 1 | Output device has taken the byte |

## Verification
The input path is driven with every one of the 256 byte values. For each value the bench polls the status word, reads the data register and polls the status again. This separates a stuck or shifted data bit from a flag that fails to set or fails to clear.

The output path is also driven with all 256 values, each carrying a different upper byte, followed by a second write while busy. This shows whether the upper byte leaks onto the device, and whether a busy write is dropped rather than overwriting the pending byte.

Every address below the window is swept with a combined read and write of all-ones. Writes to the wrong registers inside the window are also tried. Together these show whether the decoder aliases other addresses onto the four registers.

The overlap cases are each applied on their own: an arrival while the flag is set, an arrival in the same cycle as a data read, and an acknowledge while idle.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;

    localparam int BP_ADDR_W = 12;
    localparam int BP_DATA_W = 16;
    localparam int BP_BYTE_W = 8;
    localparam int BP_SLOTS  = 4;

    // register slot index inside the decoded window; the offset order is
    // fixed because software relies on the address of each register
    typedef enum logic [1:0] {
        SLOT_RX_DATA = 2'd0,
        SLOT_RX_STAT = 2'd1,
        SLOT_TX_DATA = 2'd2,
        SLOT_TX_STAT = 2'd3
    } slot_e;

endpackage

// File: rtl/bp_decode.sv
module bp_decode #(
    parameter int                  ADDR_W = byte_port_pkg::BP_ADDR_W,
    parameter int                  SLOTS  = byte_port_pkg::BP_SLOTS,
    parameter logic [ADDR_W-1:0]   BASE   = 12'hFFC
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [SLOTS-1:0]  rd_sel,
    output logic [SLOTS-1:0]  wr_sel
);

    logic [SLOTS-1:0] hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE + ADDR_W'(g);
        assign hit[g]    = (addr == SLOT_ADDR);
        assign rd_sel[g] = rd & hit[g];
        assign wr_sel[g] = wr & hit[g];
    end

endmodule

// File: rtl/bp_rx_chan.sv
module bp_rx_chan #(
    parameter int BYTE_W = byte_port_pkg::BP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              take,
    output logic              avail,
    output logic [BYTE_W-1:0] held
);

    typedef struct packed {
        logic              avail;
        logic [BYTE_W-1:0] held;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.avail = 1'b0;
        end
        // an arrival wins over a read in the same cycle and replaces any
        // byte that software has not collected yet
        if (in_valid) begin
            st_d.avail = 1'b1;
            st_d.held  = in_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail = st_q.avail;
    assign held  = st_q.held;

endmodule

// File: rtl/bp_tx_chan.sv
module bp_tx_chan #(
    parameter int BYTE_W = byte_port_pkg::BP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              ack,
    output logic              busy,
    output logic [BYTE_W-1:0] out_byte
);

    typedef struct packed {
        logic              busy;
        logic [BYTE_W-1:0] pend;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            // loads while busy are dropped; only the device can release
            if (ack) begin
                st_d.busy = 1'b0;
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.pend = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign out_byte = st_q.pend;

endmodule

// File: rtl/byte_port_io.sv
module byte_port_io #(
    parameter int                ADDR_W = byte_port_pkg::BP_ADDR_W,
    parameter int                DATA_W = byte_port_pkg::BP_DATA_W,
    parameter int                BYTE_W = byte_port_pkg::BP_BYTE_W,
    parameter logic [ADDR_W-1:0] BASE   = 12'hFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dev_in_valid,
    input  logic [BYTE_W-1:0] dev_in_byte,
    output logic              dev_out_valid,
    output logic [BYTE_W-1:0] dev_out_byte,
    input  logic              dev_out_ack
);
    import byte_port_pkg::*;

    localparam int SLOTS   = BP_SLOTS;
    localparam int SIGN    = DATA_W - 1;
    localparam int I_RXD   = int'(SLOT_RX_DATA);
    localparam int I_RXS   = int'(SLOT_RX_STAT);
    localparam int I_TXD   = int'(SLOT_TX_DATA);
    localparam int I_TXS   = int'(SLOT_TX_STAT);

    logic [SLOTS-1:0]  rd_sel;
    logic [SLOTS-1:0]  wr_sel;
    logic              rx_avail;
    logic [BYTE_W-1:0] rx_held;
    logic              tx_busy;

    bp_decode #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS),
        .BASE   (BASE)
    ) i_decode (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    bp_rx_chan #(
        .BYTE_W (BYTE_W)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (dev_in_valid),
        .in_byte  (dev_in_byte),
        .take     (rd_sel[I_RXD]),
        .avail    (rx_avail),
        .held     (rx_held)
    );

    bp_tx_chan #(
        .BYTE_W (BYTE_W)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_sel[I_TXD]),
        .load_byte (bus_wdata[BYTE_W-1:0]),
        .ack       (dev_out_ack),
        .busy      (tx_busy),
        .out_byte  (dev_out_byte)
    );

    // read return: zero-extended byte or a sign-bit flag, else zero
    always_comb begin
        bus_rdata = '0;
        if (rd_sel[I_RXD]) begin
            bus_rdata[BYTE_W-1:0] = rx_held;
        end
        if (rd_sel[I_RXS]) begin
            bus_rdata[SIGN] = rx_avail;
        end
        if (rd_sel[I_TXS]) begin
            bus_rdata[SIGN] = ~tx_busy;
        end
    end

    assign dev_out_valid = tx_busy;

    logic unused_inputs;
    assign unused_inputs = ^{bus_wdata[DATA_W-1:BYTE_W], wr_sel};

endmodule

// File: rtl/byte_port_io_chk.sv
module byte_port_io_chk #(
    parameter int                ADDR_W = 12,
    parameter int                DATA_W = 16,
    parameter int                BYTE_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 12'hFFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dev_in_valid,
    input logic              dev_out_valid,
    input logic [BYTE_W-1:0] dev_out_byte,
    input logic              dev_out_ack,
    input logic              rx_avail
);

    localparam logic [ADDR_W-1:0] A_RXD = BASE;
    localparam logic [ADDR_W-1:0] A_RXS = BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TXD = BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_TXS = BASE + ADDR_W'(3);

    // R4
    arrival_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_valid |=> rx_avail);

    // R5
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXD && !dev_in_valid) |=> !rx_avail);

    // R2
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXD) |-> (bus_rdata[DATA_W-1:BYTE_W] == '0));

    // R3
    rx_status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXS) |-> (bus_rdata[DATA_W-2:0] == '0));

    // R7
    tx_status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_TXS) |->
            (bus_rdata[DATA_W-1] == !dev_out_valid && bus_rdata[DATA_W-2:0] == '0));

    // R6
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXD && !dev_out_valid) |=>
            (dev_out_valid && dev_out_byte == $past(bus_wdata[BYTE_W-1:0])));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ack) |=> (dev_out_valid && $stable(dev_out_byte)));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && dev_out_ack) |=> !dev_out_valid);

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_addr < BASE) |-> (bus_rdata == '0));

    // R11
    write_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_TXD) |-> (bus_rdata == '0));

endmodule

bind byte_port_io byte_port_io_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .BASE   (BASE)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .dev_in_valid  (dev_in_valid),
    .dev_out_valid (dev_out_valid),
    .dev_out_byte  (dev_out_byte),
    .dev_out_ack   (dev_out_ack),
    .rx_avail      (rx_avail)
);

// File: tb/test_byte_port_io.sv
module test_byte_port_io;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_RXD = 12'hFFC;
    localparam logic [11:0] A_RXS = 12'hFFD;
    localparam logic [11:0] A_TXD = 12'hFFE;
    localparam logic [11:0] A_TXS = 12'hFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dev_in_valid = 1'b0;
    logic [7:0]  dev_in_byte = '0;
    logic        dev_out_valid;
    logic [7:0]  dev_out_byte;
    logic        dev_out_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_port_io i_byte_port_io (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .dev_in_valid  (dev_in_valid),
        .dev_in_byte   (dev_in_byte),
        .dev_out_valid (dev_out_valid),
        .dev_out_byte  (dev_out_byte),
        .dev_out_ack   (dev_out_ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd_word(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        dev_in_valid = 1'b1;
        dev_in_byte  = b;
        @(negedge clk);
        dev_in_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        dev_out_ack = 1'b1;
        @(negedge clk);
        dev_out_ack = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state; R10 idle bus reads zero
        chk("R10 idle rdata", bus_rdata, 16'h0000);
        chk("R1 out valid", {15'd0, dev_out_valid}, 16'h0000);
        rd_word(A_RXS, d); chk("R1 rx status", d, 16'h0000);
        rd_word(A_TXS, d); chk("R1 tx status", d, 16'h8000);

        // R2 R3 R4 R5 exhaustive input sweep
        bad = 0;
        for (int b = 0; b < 256; b++) begin
            push_byte(8'(b));
            rd_word(A_RXS, d); chk("R3 R4 flag set", d, 16'h8000);
            rd_word(A_RXD, d); chk("R2 data", d, {8'h00, 8'(b)});
            rd_word(A_RXS, d); chk("R5 flag cleared", d, 16'h0000);
        end

        // R4 overwrite while flag set
        push_byte(8'h5A);
        push_byte(8'hC3);
        rd_word(A_RXD, d); chk("R4 overwrite", d, 16'h00C3);

        // R5 arrival in the same cycle as the data read
        push_byte(8'h11);
        dev_in_valid = 1'b1;
        dev_in_byte  = 8'h22;
        rd_word(A_RXD, d); chk("R5 old byte returned", d, 16'h0011);
        dev_in_valid = 1'b0;
        rd_word(A_RXS, d); chk("R5 flag kept", d, 16'h8000);
        rd_word(A_RXD, d); chk("R5 new byte held", d, 16'h0022);

        // R9 ack while idle has no effect
        pulse_ack();
        chk("R9 idle ack", {15'd0, dev_out_valid}, 16'h0000);
        rd_word(A_TXS, d); chk("R9 idle ack ready", d, 16'h8000);

        // R6 R7 R8 R9 exhaustive output sweep
        for (int b = 0; b < 256; b++) begin
            wr_word(A_TXD, {8'(b) ^ 8'h3C, 8'(b)});
            chk("R6 valid", {15'd0, dev_out_valid}, 16'h0001);
            chk("R6 byte", {8'h00, dev_out_byte}, {8'h00, 8'(b)});
            rd_word(A_TXS, d); chk("R7 busy status", d, 16'h0000);
            wr_word(A_TXD, {8'hFF, ~8'(b)});
            chk("R8 dropped write", {7'd0, dev_out_valid, dev_out_byte}, {7'd0, 1'b1, 8'(b)});
            pulse_ack();
            chk("R9 released", {15'd0, dev_out_valid}, 16'h0000);
            rd_word(A_TXS, d); chk("R7 ready status", d, 16'h8000);
        end

        // R11 write-only register reads zero, writes to other slots ignored
        rd_word(A_TXD, d); chk("R11 read of out data", d, 16'h0000);
        wr_word(A_RXD, 16'hFFFF);
        wr_word(A_RXS, 16'hFFFF);
        wr_word(A_TXS, 16'hFFFF);
        rd_word(A_RXS, d); chk("R11 rx flag untouched", d, 16'h0000);
        chk("R11 tx untouched", {15'd0, dev_out_valid}, 16'h0000);
        push_byte(8'h77);
        wr_word(A_RXD, 16'h0000);
        rd_word(A_RXS, d); chk("R11 write does not clear", d, 16'h8000);
        rd_word(A_RXD, d); chk("R11 held byte kept", d, 16'h0077);

        // R10 sweep every address below the window
        bad = 0;
        for (int a = 0; a < 12'hFFC; a++) begin
            bus_addr  = 12'(a);
            bus_wdata = 16'hFFFF;
            bus_rd    = 1'b1;
            bus_wr    = 1'b1;
            #1 if (bus_rdata !== 16'h0000) bad++;
            @(negedge clk);
        end
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        chk("R10 unmapped reads nonzero count", 16'(bad), 16'h0000);
        chk("R10 unmapped writes launch", {15'd0, dev_out_valid}, 16'h0000);
        rd_word(A_RXS, d); chk("R10 unmapped rx flag", d, 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule